// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block is the device-side controller of a small byte-wide flash array while it works through an internal program or erase operation. It takes single-cycle commands. A command either programs one byte, erases one sector, erases the whole array, or clears a latched error. While an operation is in flight, reads that fall inside the affected range do not return the array contents. They return a status byte that software can poll to learn whether the operation is still running, has finished, or has failed.

The array is held in registers and resets to the erased value. Programming can only clear bits. Erasing sets whole bytes back to all ones, either for one sector or for the full array. An operation runs for a fixed, parameterised number of cycles. An independent timeout limit aborts any operation that would run longer.

A program that asks for a 1 where the array holds a 0 is refused at once. A failed operation leaves the block in a latched error state until a clear command arrives. The `busy` output is high only while an operation is running.

Top module: `flash_status_engine`

## Requirements
- R1: After reset `busy` is 0, `rd_data` is 8'h00, and every array byte reads as 8'hFF.
- R2: A program command (`cmd_op`=2'b01) accepted while idle raises `busy` for exactly PROG_CYCLES cycles. Afterwards the target byte holds the old value ANDed with `cmd_data`.
- R3: An erase command raises `busy` for exactly ERASE_CYCLES cycles and then writes 8'hFF to the erased range. With `cmd_op`=2'b10 the range is the sector selected by the top SECT_W address bits (16 bytes by default). With `cmd_op`=2'b11 the range is the whole array. Bytes outside the range are unchanged.
- R4: While a program runs, a read of the target address returns a status byte. Bit 7 is the inverse of bit 7 of the data being written, bit 5 is 0, and bits 4:0 are 0. After completion the same address reads the stored data.
- R5: While an erase runs, a read of any address in the erased range returns a status byte with bit 7 = 0 and bit 5 = 0.
- R6: Status bit 6 is cleared to 0 when a command is accepted. It inverts after every status read while the operation runs, so two back-to-back status reads differ in bit 6.
- R7: A read returns data one cycle after `rd_en`. Reads while idle, and reads outside the busy range, return array contents.
- R8: A program that would set a bit that currently holds 0 leaves the byte unchanged and never raises `busy`. The block enters the error state at once. A status read of the target then has bit 5 = 1 and bit 7 = the inverse of data bit 7.
- R9: When the operation length exceeds TMO_CYCLES, `busy` drops after TMO_CYCLES cycles. The array is not changed, and the block enters the error state, whose status has bit 5 = 1.
- R10: In the error state the status byte is frozen and repeated reads return the same value. Program and erase commands are ignored. Only a clear command (`cmd_op`=2'b00) returns the block to idle.
- R11: Commands issued while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 00 clear error, 01 program, 10 erase sector, 11 erase all |
| cmd_addr | input | ADDR_W | Byte address for program, any address in the sector for sector erase |
| cmd_data | input | 8 | Data to program |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result: array byte or status byte |
| busy | output | 1 | High while an operation runs |

## Verification
A table of commands drives the main function, with each entry followed by a read-back. The table covers fresh programs into erased bytes and further programs that only clear more bits. It also covers sector and full-array erases checked against a neighbouring sector, and a refused 1-over-0 program. Together these separate correct AND-style storage and range selection from a design that overwrites or erases too widely. Directed polling runs then read during operations with data bit 7 both set and clear, read inside and outside the busy range, and read twice in a row. This tells apart the polling, toggle and pass-through paths. A second instance with an erase longer than its timeout shows the abort path and that the array stays intact.

// File: rtl/flash_status_engine.sv
module flash_status_engine #(
  parameter int ADDR_W       = 6,
  parameter int SECT_W       = 2,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 24,
  parameter int TMO_CYCLES   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int SECT_SH = ADDR_W - SECT_W;
  localparam int OPMAX   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int MAXC    = (OPMAX > TMO_CYCLES) ? OPMAX : TMO_CYCLES;
  localparam int CNT_W   = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(TMO_CYCLES - 1);
  localparam logic [1:0] OP_CLR = 2'b00, OP_PROG = 2'b01, OP_SECT = 2'b10, OP_ALL = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_ERR} state_t;

  state_t            state_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [7:0]        op_data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tog_q;
  logic [7:0]        mem [DEPTH];

  logic             rd_hit, in_err, accept, clear, illegal, finish, expire;
  logic [CNT_W-1:0] last;
  logic [7:0]       status_byte;

  always_comb begin
    case (op_q)
      OP_PROG: rd_hit = (rd_addr == op_addr_q);
      OP_SECT: rd_hit = (rd_addr[ADDR_W-1 -: SECT_W] == op_addr_q[ADDR_W-1 -: SECT_W]);
      default: rd_hit = 1'b1;
    endcase
  end

  assign in_err      = (state_q == S_ERR);
  assign busy        = (state_q == S_RUN);
  assign accept      = cmd_valid && (state_q == S_IDLE) && (cmd_op != OP_CLR);
  assign clear       = cmd_valid && in_err && (cmd_op == OP_CLR);
  assign illegal     = (cmd_op == OP_PROG) && |(cmd_data & ~mem[cmd_addr]);
  assign last        = (op_q == OP_PROG) ? PROG_LAST : ERASE_LAST;
  assign finish      = busy && (cnt_q == last);
  assign expire      = busy && !finish && (cnt_q == TMO_LAST);
  assign status_byte = {(op_q == OP_PROG) & ~op_data_q[7], tog_q, in_err, 5'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      op_q      <= OP_CLR;
      op_addr_q <= '0;
      op_data_q <= '0;
      cnt_q     <= '0;
      tog_q     <= 1'b0;
    end else begin
      if (accept) begin
        state_q   <= illegal ? S_ERR : S_RUN;
        op_q      <= cmd_op;
        op_addr_q <= cmd_addr;
        op_data_q <= cmd_data;
        cnt_q     <= '0;
        tog_q     <= 1'b0;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
        if (rd_en && rd_hit) tog_q <= ~tog_q;
        if (finish) state_q <= S_IDLE;
        else if (expire) state_q <= S_ERR;
      end else if (clear) begin
        state_q <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (finish) begin
      if (op_q == OP_PROG) begin
        mem[op_addr_q] <= mem[op_addr_q] & op_data_q;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (op_q == OP_ALL || (i >> SECT_SH) == int'(op_addr_q[ADDR_W-1 -: SECT_W]))
            mem[i] <= 8'hFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= 8'h00;
    else if (rd_en) rd_data <= ((state_q != S_IDLE) && rd_hit) ? status_byte : mem[rd_addr];
  end
endmodule

// File: rtl/flash_status_engine_chk.sv
module flash_status_engine_chk #(
  parameter int ADDR_W     = 6,
  parameter int TMO_CYCLES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              busy,
  input logic              err_st,
  input logic              tog,
  input logic              hit,
  input logic [ADDR_W-1:0] op_addr
);
  localparam int RW = $clog2(TMO_CYCLES + 1) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < RW'(TMO_CYCLES)));

  assert_busy_from_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  assert_busy_locks_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(op_addr));

  assert_err_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_st && $past(err_st)) |-> $stable(tog));

  assert_err_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_st && rd_en && hit) |=> rd_data[5]);
endmodule

bind flash_status_engine flash_status_engine_chk #(.ADDR_W(ADDR_W), .TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .rd_en(rd_en), .rd_data(rd_data),
  .busy(busy), .err_st(in_err), .tog(tog_q), .hit(rd_hit), .op_addr(op_addr_q)
);

// File: tb/sim_flash_status_engine.sv
module sim_flash_status_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [5:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic       rd_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic       sel1 = 1'b0;
  logic [7:0] rd0, rd1;
  logic       busy0, busy1;
  wire        bsy = sel1 ? busy1 : busy0;

  flash_status_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid & ~sel1), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd0), .busy(busy0));

  flash_status_engine #(.ERASE_CYCLES(40), .TMO_CYCLES(16)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid & sel1), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd1), .busy(busy1));

  // {op, addr, data, check_addr, expected, expect_error}
  localparam logic [30:0] VEC [8] = '{
    {2'b01, 6'h05, 8'hA5, 6'h05, 8'hA5, 1'b0},
    {2'b01, 6'h05, 8'h21, 6'h05, 8'h21, 1'b0},
    {2'b01, 6'h12, 8'h3C, 6'h12, 8'h3C, 1'b0},
    {2'b10, 6'h03, 8'h00, 6'h05, 8'hFF, 1'b0},
    {2'b01, 6'h13, 8'h0F, 6'h12, 8'h3C, 1'b0},
    {2'b11, 6'h00, 8'h00, 6'h12, 8'hFF, 1'b0},
    {2'b01, 6'h3F, 8'h00, 6'h3F, 8'h00, 1'b0},
    {2'b01, 6'h3F, 8'h01, 6'h3F, 8'h00, 1'b1}
  };

  int checks = 0;
  int fails = 0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [5:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    v = sel1 ? rd1 : rd0;
    rd_en = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (bsy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [30:0] v;
    logic [7:0]  r, r2;
    int          n;
    string       tg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", {7'b0, busy0}, 8'h00);
    check("R1 rd_data", rd0, 8'h00);
    rd(6'h2C, r); check("R1 erased array", r, 8'hFF);

    for (int k = 0; k < 8; k++) begin
      v = VEC[k];
      tg = (v[0]) ? "R8" : ((v[30:29] == 2'b01) ? "R2" : "R3");
      cmd(v[30:29], v[28:23], v[22:15]);
      wait_idle(n);
      check({tg, " busy length"}, 8'(n), v[0] ? 8'd0 : ((v[30:29] == 2'b01) ? 8'd8 : 8'd24));
      if (v[0]) begin
        rd(v[28:23], r); check("R8 error bit", {7'b0, r[5]}, 8'h01);
        cmd(2'b00, 6'h00, 8'h00);
      end
      rd(v[14:9], r); check({tg, " readback"}, r, v[8:1]);
    end

    // polling while programming, bit 7 of data clear
    cmd(2'b01, 6'h08, 8'h55);
    rd(6'h08, r);  check("R4 poll bit7 inverted", r, 8'h80);
    rd(6'h08, r);  check("R6 toggle on second read", r, 8'hC0);
    rd(6'h09, r);  check("R7 outside range", r, 8'hFF);
    cmd(2'b01, 6'h30, 8'h00);
    wait_idle(n);
    rd(6'h08, r);  rd(6'h08, r2);
    check("R4 data after completion", r, 8'h55);
    check("R6 no toggle when done", r2, r);
    rd(6'h30, r);  check("R11 command while busy ignored", r, 8'hFF);

    // bit 7 of data set
    cmd(2'b01, 6'h09, 8'h9A);
    rd(6'h09, r);  check("R4 poll bit7 with data bit7 set", r, 8'h00);
    wait_idle(n);
    rd(6'h09, r);  check("R4 data after completion", r, 8'h9A);

    // sector erase status
    cmd(2'b01, 6'h1A, 8'h11);
    wait_idle(n);
    cmd(2'b10, 6'h10, 8'h00);
    rd(6'h1A, r);  check("R5 erase status", r, 8'h00);
    rd(6'h1B, r);  check("R6 erase toggle", r, 8'h40);
    rd(6'h2A, r);  check("R7 other sector during erase", r, 8'hFF);
    rd(6'h08, r);  check("R7 sector 0 during erase", r, 8'h55);
    wait_idle(n);
    rd(6'h1A, r);  check("R3 sector erased", r, 8'hFF);
    rd(6'h08, r);  check("R3 sector 0 kept", r, 8'h55);

    // illegal program and frozen error state
    cmd(2'b01, 6'h08, 8'hFF);
    check("R8 no busy on illegal program", {7'b0, busy0}, 8'h00);
    rd(6'h08, r);  check("R8 error status", r, 8'h20);
    rd(6'h08, r);  check("R10 status frozen", r, 8'h20);
    cmd(2'b01, 6'h20, 8'h00);
    check("R10 no busy in error", {7'b0, busy0}, 8'h00);
    rd(6'h08, r);  check("R10 still error", r, 8'h20);
    cmd(2'b00, 6'h00, 8'h00);
    rd(6'h20, r);  check("R10 command ignored in error", r, 8'hFF);
    rd(6'h08, r);  check("R8 byte unchanged", r, 8'h55);

    // timeout on the second instance
    sel1 = 1'b1;
    cmd(2'b01, 6'h00, 8'h12);
    wait_idle(n);
    cmd(2'b11, 6'h00, 8'h00);
    wait_idle(n);
    check("R9 busy cut at timeout", 8'(n), 8'd16);
    rd(6'h00, r);  check("R9 timeout status", r, 8'h20);
    cmd(2'b00, 6'h00, 8'h00);
    rd(6'h00, r);  check("R9 array untouched", r, 8'h12);
    sel1 = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule